// File: doc/BRIEF.md
# Fieldbus datagram address and counter unit

This block sits in the byte path of a daisy-chained fieldbus slave and handles one datagram per frame while it streams through. It reads the command byte and splits it into an access type and an addressing mode. It then decides whether this slave is the target, using the position field, a programmed station address, or a logical address translated by a small table of mapping windows. When the slave is the target, it reads or writes its local register memory one data byte at a time. It also adds its share to the working counter at the end of the datagram.

Every byte leaves the block one clock after it enters. Only the position field (in position mode), the data bytes of a read, and the working counter may be rewritten; all other bytes pass through unchanged. The memory port is a simple strobe interface. Read data must return combinationally in the same cycle as the address, so a read byte can replace the passing byte without an extra stage.

Top module: `dgAddrUnit`

## Requirements
- R1: Frame layout, little-endian throughout. Byte 0 is the command. Byte 1 is an index that passes through untouched. Bytes 2-3 hold the position field, bytes 4-5 the offset field, bytes 6-7 the data length N. Then come N data bytes and a 2-byte working counter. In the command, bits [1:0] give the access (0 none, 1 read, 2 write, 3 read-write) and bits [3:2] give the mode (0 position, 1 configured, 2 broadcast, 3 logical).
- R2: Each input byte reappears on the output exactly one clock later, together with its start and end strobes. Any byte not named in R3, R7, R9 or R10 is forwarded unchanged.
- R3: In position mode the forwarded position field is the received value plus one, modulo 2^16, with carry from the low byte into the high byte. The slave is addressed only when the received value is zero.
- R4: In configured mode the slave is addressed when the position field equals the station address input, whatever its place in the chain. The position field is forwarded unchanged.
- R5: In broadcast mode the slave is always addressed.
- R6: In logical mode, bytes 2-5 form a 32-bit logical address L. A window with logical start S, length W and physical start P hits when L >= S and (L - S) + N <= W. The physical base is then P + (L - S). The lowest-numbered window that hits is used. When no window hits, the slave is not addressed.
- R7: For an addressed read, data byte i raises the read strobe with memory address base + i. The forwarded byte is replaced by the read data. The base is the offset field, or the translated base in logical mode.
- R8: For an addressed write, data byte i raises the write strobe at base + i, with the incoming byte as write data. The byte is forwarded unchanged.
- R9: For an addressed read-write, each data byte raises both strobes at the same address. The forwarded byte carries the old memory contents, and the memory receives the incoming byte.
- R10: The forwarded working counter is the received 16-bit value plus 1 for a read or a write, plus 3 for a read-write, and plus 0 for a no-op or when the slave is not addressed.
- R11: When the slave is not addressed, no memory strobe is raised and the data bytes pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inSof | input | 1 | First byte of a frame (command byte) |
| inEof | input | 1 | Last byte of a frame (working counter high byte) |
| stationAddr | input | 16 | Programmed station address for configured mode |
| winLogStart | input | NumWin*32 | Logical start of each mapping window |
| winLength | input | NumWin*16 | Length in bytes of each window |
| winPhysStart | input | NumWin*16 | Physical start of each window |
| memRdata | input | 8 | Read data for the current memory address, same cycle |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outSof | output | 1 | Output start strobe |
| outEof | output | 1 | Output end strobe |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memAddr | output | 16 | Memory address |
| memWdata | output | 8 | Memory write data |

## Verification
The assertions assume well-formed frames. Each frame opens with inSof on its command byte and closes with inEof on the high counter byte, and the length field matches the number of data bytes. They also assume memRdata is valid in the same cycle as memAddr. The stimulus builds every frame from its own length, so the data count and the counter position always agree. Logical addresses and offsets are kept inside a 256-byte model memory, and frames are separated by idle cycles so that strobe runs never join across frames.

// File: rtl/dgProcPkg.sv
package dgProcPkg;
  localparam int FieldW = 16;
  localparam int LogW   = 32;

  typedef enum logic [1:0] {ACC_NONE, ACC_READ, ACC_WRITE, ACC_RDWR} accType_e;
  typedef enum logic [1:0] {MODE_POS, MODE_CFG, MODE_BCAST, MODE_LOG} addrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       capAdpLo;
    logic       capAdpHi;
    logic       capAdoLo;
    logic       capAdoHi;
    logic       capLenLo;
    logic       capLenHi;
    logic       incAdpLo;
    logic       incAdpHi;
    logic       addWkcLo;
    logic       addWkcHi;
    logic [1:0] wkcInc;
    logic       selRead;
    logic       useLog;
  } dpCtl_t;

  function automatic logic [1:0] wkcStep(accType_e a);
    case (a)
      ACC_READ, ACC_WRITE: return 2'd1;
      ACC_RDWR:            return 2'd3;
      default:             return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/dgLogMap.sv
module dgLogMap
  import dgProcPkg::*;
#(
  parameter int NumWin = 2
) (
  input  logic [LogW-1:0]                logAddr,
  input  logic [FieldW-1:0]              spanLen,
  input  logic [NumWin-1:0][LogW-1:0]    winLogStart,
  input  logic [NumWin-1:0][FieldW-1:0]  winLength,
  input  logic [NumWin-1:0][FieldW-1:0]  winPhysStart,
  output logic                           hit,
  output logic [FieldW-1:0]              physBase
);
  localparam int RelW = LogW + 1;

  logic [NumWin-1:0]             wHit;
  logic [NumWin-1:0][FieldW-1:0] wBase;

  for (genvar g = 0; g < NumWin; g++) begin : g_win
    logic [RelW-1:0] rel;
    logic [RelW-1:0] spanEnd;
    assign rel     = {1'b0, logAddr} - {1'b0, winLogStart[g]};
    assign spanEnd = rel + RelW'(spanLen);
    assign wHit[g]  = !rel[RelW-1] && (spanEnd <= RelW'(winLength[g]));
    assign wBase[g] = winPhysStart[g] + rel[FieldW-1:0];
  end

  // lowest index wins: scan from the top down so it overrides last
  always_comb begin
    hit      = 1'b0;
    physBase = '0;
    for (int i = NumWin - 1; i >= 0; i--) begin
      if (wHit[i]) begin
        hit      = 1'b1;
        physBase = wBase[i];
      end
    end
  end
endmodule

// File: rtl/dgPath.sv
module dgPath
  import dgProcPkg::*;
#(
  parameter int NumWin = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           inValid,
  input  logic [7:0]                     inData,
  input  logic                           inSof,
  input  logic                           inEof,
  input  logic [FieldW-1:0]              stationAddr,
  input  logic [NumWin-1:0][LogW-1:0]    winLogStart,
  input  logic [NumWin-1:0][FieldW-1:0]  winLength,
  input  logic [NumWin-1:0][FieldW-1:0]  winPhysStart,
  input  logic [7:0]                     memRdata,
  input  dpCtl_t                         ctl,
  input  logic [FieldW-1:0]              dataIdx,
  output logic                           adpZero,
  output logic                           adpIsStation,
  output logic                           logHit,
  output logic [FieldW-1:0]              lenNow,
  output logic [FieldW-1:0]              memAddr,
  output logic [7:0]                     memWdata,
  output logic                           outValid,
  output logic [7:0]                     outData,
  output logic                           outSof,
  output logic                           outEof
);
  logic [FieldW-1:0] adpReg, adoReg, lenReg;
  logic [7:0]        lenLoReg;
  logic              carry;
  logic [FieldW-1:0] logBase, baseAddr;
  logic [7:0]        addend, nextByte;
  logic [8:0]        sum9;
  logic              doAdd;

  assign adpZero      = (adpReg == '0);
  assign adpIsStation = (adpReg == stationAddr);
  assign lenNow       = ctl.capLenHi ? {inData, lenLoReg} : lenReg;

  dgLogMap #(.NumWin(NumWin)) u_map (
    .logAddr     ({adoReg, adpReg}),
    .spanLen     (lenNow),
    .winLogStart (winLogStart),
    .winLength   (winLength),
    .winPhysStart(winPhysStart),
    .hit         (logHit),
    .physBase    (logBase)
  );

  assign baseAddr = ctl.useLog ? logBase : adoReg;
  assign memAddr  = baseAddr + dataIdx;
  assign memWdata = inData;

  always_comb begin
    doAdd = ctl.incAdpLo | ctl.incAdpHi | ctl.addWkcLo | ctl.addWkcHi;
    if (ctl.incAdpLo)                     addend = 8'd1;
    else if (ctl.addWkcLo)                addend = {6'd0, ctl.wkcInc};
    else if (ctl.incAdpHi | ctl.addWkcHi) addend = {7'd0, carry};
    else                                  addend = 8'd0;
    sum9 = {1'b0, inData} + {1'b0, addend};
    if (ctl.selRead)  nextByte = memRdata;
    else if (doAdd)   nextByte = sum9[7:0];
    else              nextByte = inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adpReg   <= '0;
      adoReg   <= '0;
      lenReg   <= '0;
      lenLoReg <= '0;
      carry    <= 1'b0;
      outValid <= 1'b0;
      outData  <= '0;
      outSof   <= 1'b0;
      outEof   <= 1'b0;
    end else begin
      if (ctl.capAdpLo) adpReg[7:0]  <= inData;
      if (ctl.capAdpHi) adpReg[15:8] <= inData;
      if (ctl.capAdoLo) adoReg[7:0]  <= inData;
      if (ctl.capAdoHi) adoReg[15:8] <= inData;
      if (ctl.capLenLo) lenLoReg     <= inData;
      if (ctl.capLenHi) lenReg       <= {inData, lenLoReg};
      if (ctl.incAdpLo | ctl.addWkcLo) carry <= sum9[8];
      outValid <= inValid;
      outSof   <= inValid & inSof;
      outEof   <= inValid & inEof;
      outData  <= nextByte;
    end
  end
endmodule

// File: rtl/dgCtrl.sv
module dgCtrl
  import dgProcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSof,
  input  logic              inEof,
  input  logic [3:0]        cmdIn,
  input  logic              adpZero,
  input  logic              adpIsStation,
  input  logic              logHit,
  input  logic [FieldW-1:0] lenNow,
  output dpCtl_t            ctl,
  output logic [FieldW-1:0] dataIdx,
  output logic              memRd,
  output logic              memWr
);
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_DATA, ST_WKCLO, ST_WKCHI, ST_TAIL} state_e;

  state_e            state;
  logic [2:0]        hdrIdx;
  logic [3:0]        cmdReg;
  logic              hitReg;
  logic [FieldW-1:0] remain;
  logic              inHdr, addrHit;
  logic [2:0]        hb;
  addrMode_e         mode;
  accType_e          acc;

  assign mode  = addrMode_e'(cmdReg[3:2]);
  assign acc   = accType_e'(cmdReg[1:0]);
  assign inHdr = inValid && (inSof || state == ST_HDR);
  assign hb    = inSof ? 3'd0 : hdrIdx;

  always_comb begin
    case (mode)
      MODE_POS:   addrHit = adpZero;
      MODE_CFG:   addrHit = adpIsStation;
      MODE_BCAST: addrHit = 1'b1;
      default:    addrHit = logHit;
    endcase
  end

  always_comb begin
    ctl        = '0;
    ctl.useLog = (mode == MODE_LOG);
    ctl.wkcInc = hitReg ? wkcStep(acc) : 2'd0;
    memRd      = 1'b0;
    memWr      = 1'b0;
    if (inHdr) begin
      case (hb)
        3'd2: begin ctl.capAdpLo = 1'b1; ctl.incAdpLo = (mode == MODE_POS); end
        3'd3: begin ctl.capAdpHi = 1'b1; ctl.incAdpHi = (mode == MODE_POS); end
        3'd4: ctl.capAdoLo = 1'b1;
        3'd5: ctl.capAdoHi = 1'b1;
        3'd6: ctl.capLenLo = 1'b1;
        3'd7: ctl.capLenHi = 1'b1;
        default: ;
      endcase
    end else if (inValid && !inSof) begin
      case (state)
        ST_DATA: begin
          memRd       = hitReg && (acc == ACC_READ || acc == ACC_RDWR);
          memWr       = hitReg && (acc == ACC_WRITE || acc == ACC_RDWR);
          ctl.selRead = memRd;
        end
        ST_WKCLO: ctl.addWkcLo = 1'b1;
        ST_WKCHI: ctl.addWkcHi = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      hdrIdx  <= '0;
      cmdReg  <= '0;
      hitReg  <= 1'b0;
      remain  <= '0;
      dataIdx <= '0;
    end else if (inValid) begin
      if (inSof) begin
        cmdReg <= cmdIn;
        hdrIdx <= 3'd1;
        hitReg <= 1'b0;
        state  <= ST_HDR;
      end else begin
        case (state)
          ST_HDR: begin
            hdrIdx <= hdrIdx + 3'd1;
            if (hdrIdx == 3'd7) begin
              hitReg  <= addrHit;
              remain  <= lenNow;
              dataIdx <= '0;
              state   <= (lenNow == '0) ? ST_WKCLO : ST_DATA;
            end
          end
          ST_DATA: begin
            dataIdx <= dataIdx + 1'b1;
            remain  <= remain - 1'b1;
            if (remain == 16'd1) state <= ST_WKCLO;
          end
          ST_WKCLO: state <= ST_WKCHI;
          ST_WKCHI: state <= ST_TAIL;
          default: ;
        endcase
      end
      if (inEof) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/dgAddrUnit.sv
module dgAddrUnit
  import dgProcPkg::*;
#(
  parameter int NumWin = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           inValid,
  input  logic [7:0]                     inData,
  input  logic                           inSof,
  input  logic                           inEof,
  input  logic [FieldW-1:0]              stationAddr,
  input  logic [NumWin-1:0][LogW-1:0]    winLogStart,
  input  logic [NumWin-1:0][FieldW-1:0]  winLength,
  input  logic [NumWin-1:0][FieldW-1:0]  winPhysStart,
  input  logic [7:0]                     memRdata,
  output logic                           outValid,
  output logic [7:0]                     outData,
  output logic                           outSof,
  output logic                           outEof,
  output logic                           memRd,
  output logic                           memWr,
  output logic [FieldW-1:0]              memAddr,
  output logic [7:0]                     memWdata
);
  dpCtl_t            ctl;
  logic [FieldW-1:0] dataIdx, lenNow;
  logic              adpZero, adpIsStation, logHit;

  dgCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .cmdIn(inData[3:0]), .adpZero(adpZero), .adpIsStation(adpIsStation),
    .logHit(logHit), .lenNow(lenNow), .ctl(ctl), .dataIdx(dataIdx),
    .memRd(memRd), .memWr(memWr)
  );

  dgPath #(.NumWin(NumWin)) u_path (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inSof(inSof),
    .inEof(inEof), .stationAddr(stationAddr), .winLogStart(winLogStart),
    .winLength(winLength), .winPhysStart(winPhysStart), .memRdata(memRdata),
    .ctl(ctl), .dataIdx(dataIdx), .adpZero(adpZero), .adpIsStation(adpIsStation),
    .logHit(logHit), .lenNow(lenNow), .memAddr(memAddr), .memWdata(memWdata),
    .outValid(outValid), .outData(outData), .outSof(outSof), .outEof(outEof)
  );
endmodule

// File: rtl/dgAddrUnitChk.sv
module dgAddrUnitChk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inSof,
  input logic        outValid,
  input logic        outSof,
  input logic [7:0]  outData,
  input logic [7:0]  memRdata,
  input logic        memRd,
  input logic        memWr,
  input logic [15:0] memAddr
);
  // R2
  flow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> outValid == $past(inValid));

  // R2
  sof_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> outSof == $past(inSof && inValid));

  // R7
  rdata_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> outData == $past(memRdata));

  // R11
  strobe_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> inValid);

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((memRd || memWr) && $past(memRd || memWr)) |-> memAddr == $past(memAddr) + 16'd1);
endmodule

bind dgAddrUnit dgAddrUnitChk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .outValid(outValid),
  .outSof(outSof), .outData(outData), .memRdata(memRdata), .memRd(memRd),
  .memWr(memWr), .memAddr(memAddr)
);

// File: tb/dgAddrUnit_tb.sv
module dgAddrUnit_tb;
  localparam int NumWin = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0] inData = '0;
  logic [15:0] stationAddr = 16'h1234;
  logic [NumWin-1:0][31:0] winLogStart;
  logic [NumWin-1:0][15:0] winLength, winPhysStart;
  logic [7:0] memRdata;
  logic outValid, outSof, outEof, memRd, memWr;
  logic [7:0] outData, memWdata;
  logic [15:0] memAddr;

  logic [7:0] mem [256];
  logic [7:0] refMem [256];
  int rdCnt, wrCnt;
  int nVec = 0, nBad = 0;

  always #2 clk = ~clk;

  assign winLogStart[0] = 32'h0001_0000; assign winLength[0] = 16'd16; assign winPhysStart[0] = 16'h0040;
  assign winLogStart[1] = 32'h0001_0008; assign winLength[1] = 16'd32; assign winPhysStart[1] = 16'h0080;

  dgAddrUnit #(.NumWin(NumWin)) u_dut (.*);

  assign memRdata = mem[memAddr[7:0]];
  always @(posedge clk) begin
    if (memWr) mem[memAddr[7:0]] <= memWdata;
    if (memRd) rdCnt++;
    if (memWr) wrCnt++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void winLookup(input logic [31:0] l, input int len, output bit hit, output logic [15:0] base);
    hit = 0; base = '0;
    for (int w = 0; w < NumWin; w++) begin
      if (!hit && l >= winLogStart[w] && (l - winLogStart[w]) + len <= winLength[w]) begin
        hit = 1; base = winPhysStart[w] + 16'(l - winLogStart[w]);
      end
    end
  endfunction

  task automatic runFrame(input logic [3:0] cmd, input logic [15:0] adp, input logic [15:0] ado,
                          input int len, input logic [15:0] wkc);
    logic [7:0] fr [64];
    logic [7:0] ex [64];
    string tg [64];
    bit hit; logic [15:0] base, adpOut, wkcOut, a;
    int n, expRd, expWr;
    logic [1:0] mode, acc;
    string modeTag;
    mode = cmd[3:2]; acc = cmd[1:0];
    n = 10 + len;
    fr[0] = {4'h0, cmd}; fr[1] = 8'($urandom);
    fr[2] = adp[7:0]; fr[3] = adp[15:8]; fr[4] = ado[7:0]; fr[5] = ado[15:8];
    fr[6] = 8'(len); fr[7] = 8'(len >> 8);
    for (int i = 0; i < len; i++) fr[8+i] = 8'($urandom);
    fr[8+len] = wkc[7:0]; fr[9+len] = wkc[15:8];
    base = ado;
    case (mode)
      2'd0: begin hit = (adp == 0); modeTag = "R3"; end
      2'd1: begin hit = (adp == stationAddr); modeTag = "R4"; end
      2'd2: begin hit = 1; modeTag = "R5"; end
      default: begin winLookup({ado, adp}, len, hit, base); modeTag = "R6"; end
    endcase
    for (int k = 0; k < n; k++) begin ex[k] = fr[k]; tg[k] = "R2"; end
    if (mode == 2'd0) begin
      adpOut = adp + 16'd1; ex[2] = adpOut[7:0]; ex[3] = adpOut[15:8]; tg[2] = "R3"; tg[3] = "R3";
    end
    expRd = (hit && acc[0]) ? len : 0;
    expWr = (hit && acc[1]) ? len : 0;
    for (int i = 0; i < len; i++) begin
      a = base + 16'(i);
      tg[8+i] = !hit ? "R11" : (acc == 2'd3) ? "R9" : (acc == 2'd1) ? "R7" : "R8";
      if (hit && acc[0]) ex[8+i] = refMem[a[7:0]];
      if (hit && acc[1]) refMem[a[7:0]] = fr[8+i];
    end
    wkcOut = wkc + (hit ? ((acc == 2'd3) ? 16'd3 : (acc == 2'd0) ? 16'd0 : 16'd1) : 16'd0);
    ex[8+len] = wkcOut[7:0]; ex[9+len] = wkcOut[15:8];
    tg[8+len] = "R10"; tg[9+len] = "R10";
    rdCnt = 0; wrCnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b1; inData = fr[k]; inSof = (k == 0); inEof = (k == n - 1);
      @(posedge clk); #1;
      chk(outValid && outData == ex[k] && outSof == (k == 0) && outEof == (k == n - 1),
          tg[k], {outValid, outSof, outEof, 21'd0, outData}, {1'b1, k == 0, k == n - 1, 21'd0, ex[k]});
    end
    @(negedge clk); inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    repeat (2) @(negedge clk);
    chk(rdCnt == expRd, {"R1 ", modeTag, " read strobes"}, rdCnt, expRd);
    chk(wrCnt == expWr, {"R1 ", modeTag, " write strobes"}, wrCnt, expWr);
    begin
      int diff = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== refMem[i]) diff++;
      chk(diff == 0, "R8 memory contents", diff, 0);
    end
  endtask

  initial begin
    #800000;
    nBad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 7 + 3); refMem[i] = 8'(i * 7 + 3); end
    repeat (4) @(negedge clk);
    chk(!outValid && !memRd && !memWr, "R2 reset state", {outValid, memRd, memWr}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // position mode
    runFrame(4'b0001, 16'h0000, 16'd10, 4, 16'h0005);   // R3 hit read
    runFrame(4'b0010, 16'h0003, 16'd20, 3, 16'h0000);   // R3 miss
    runFrame(4'b0011, 16'hFFFF, 16'd30, 2, 16'h0010);   // R3 wrap
    runFrame(4'b0010, 16'h00FF, 16'd30, 2, 16'h0010);   // R3 carry
    // configured
    runFrame(4'b0111, 16'h1234, 16'd40, 5, 16'h00FF);   // R4 hit rw, R10 carry
    runFrame(4'b0101, 16'h1235, 16'd40, 5, 16'h0001);   // R4 miss
    // broadcast
    runFrame(4'b1010, 16'h0042, 16'd50, 3, 16'hFFFF);   // R5 write, R10 wrap
    runFrame(4'b1001, 16'h0042, 16'd50, 0, 16'h0007);   // R5 empty data
    runFrame(4'b1000, 16'h0042, 16'd50, 3, 16'h0007);   // R10 no-op
    // logical
    runFrame(4'b1101, 16'h0000, 16'h0001, 8, 16'h0000); // R6 window 0
    runFrame(4'b1101, 16'h0008, 16'h0001, 4, 16'h0000); // R6 overlap, window 0 first
    runFrame(4'b1110, 16'h0010, 16'h0001, 4, 16'h0000); // R6 window 1 only
    runFrame(4'b1111, 16'h000E, 16'h0001, 4, 16'h0000); // R6 span past window 0
    runFrame(4'b1101, 16'h0000, 16'h0002, 4, 16'h0000); // R6 no window
    // random mix
    for (int r = 0; r < 60; r++) begin
      logic [3:0] c; logic [15:0] p, o; int l;
      c = 4'($urandom); l = $urandom_range(0, 12);
      if (c[3:2] == 2'd3) begin
        p = 16'($urandom_range(0, 28)); o = ($urandom_range(0, 3) == 0) ? 16'h0002 : 16'h0001;
      end else begin
        case ($urandom_range(0, 3))
          0: p = 16'h0000; 1: p = 16'h1234; 2: p = 16'h0001; default: p = 16'($urandom);
        endcase
        o = 16'($urandom_range(0, 200));
      end
      runFrame(c, p, o, l, 16'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule